// File: doc/BRIEF.md
# Programmable Logic Cell Bank

This block holds the sixteen output cells of one logic cluster in a sum-of-products device. Each cell receives one OR-plane sum and three product terms that are wired to it alone. It combines the sum with a helper value by XOR. The result either goes straight to the cell output or is stored in a flip-flop. The flip-flop has selectable clock, clock-enable, asynchronous set and asynchronous reset sources. Each cell also produces an output-enable value.

The last four product terms of the array are shared by every cell in the cluster. In ascending index order they are a local clock, a set, a reset and an output enable. The remaining per-cell terms tile the array in steps of three. Cell n uses term 3n+8 as term A, term 3n+9 as term B, and term 3n+10 as term C. A term that is tapped by a cell can still feed ordinary logic elsewhere. Because of this tiling, the taps of the highest cell share indices with the cluster-wide controls.

Each cell is set up by a static 11-bit word, and the word for cell n sits at bits [11n+10:11n] of the configuration bus. Within a word the fields are:
- XOR select in [1:0]
- combinational/registered choice in [2]
- clock source in [4:3]
- set source in [6:5]
- reset source in [8:7]
- output-enable source in [10:9]

Top module: `mc_bank`

## Requirements
- R1: Cell n takes term A from pterm[3n+8], term B from pterm[3n+9] and term C from pterm[3n+10]. The cluster local clock, set, reset and output enable come from pterm[52], pterm[53], pterm[54] and pterm[55].
- R2: The logic value of a cell is its OR sum XORed with a helper. The XOR select field chooses the helper: 00 gives term C, 01 gives the complement of term C, 10 gives constant 1, and 11 gives constant 0.
- R3: When bit [2] is 1, the cell output equals the logic value with no clock involved. When bit [2] is 0, the cell output equals the flip-flop state.
- R4: With clock source 11, the flip-flop loads the logic value on every rising edge of gclk.
- R5: With clock source 00, the flip-flop loads on a rising gclk edge only while term C is 1, and holds its value otherwise.
- R6: With clock source 01, the flip-flop loads on a rising edge of the cluster local clock term. With clock source 10, it loads on a rising edge of term C. In both cases gclk edges have no effect on it.
- R7: Set source 00 (term A) or 01 (cluster set) drives the flip-flop to 1 at once, without a clock, and the flip-flop keeps that value after the set is released. Codes 10 and 11 disable set.
- R8: Reset source 00 (term B) or 01 (cluster reset) drives the flip-flop to 0 at once and wins over an active set. Codes 10 and 11 disable reset. Holding rst_n low clears every flip-flop.
- R9: The output-enable field selects the enable: 00 gives term B, 01 gives the cluster output enable, 10 gives always 1, and 11 gives always 0.
- R10: A cell whose configuration word is all ones outputs its OR sum unchanged, with output enable 0.
- R11: ff_state always shows the flip-flop of every cell, even when that cell's output is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock |
| rst_n | input | 1 | Active-low asynchronous clear of all flip-flops |
| or_sum | input | 16 | One OR-plane sum per cell |
| pterm | input | 56 | All product terms of the cluster |
| cell_cfg | input | 176 | Sixteen 11-bit static configuration words |
| cell_out | output | 16 | Output value per cell |
| cell_oe | output | 16 | Output enable per cell |
| ff_state | output | 16 | Flip-flop state per cell |

## Verification
The in-line checks assume that inputs change between gclk edges and never on one. They also assume that a cell is not given a different clock source and then clocked by its new source in the same gclk cycle. Finally, they assume that a cell clocked from gclk never sees a set or reset pulse that starts and ends between two gclk edges. The stimulus respects all of this:
- Inputs are driven at falling edges, or at small offsets after them.
- After each reconfiguration, one full gclk cycle passes before any term that clocks, sets or resets a cell is pulsed.
- Set and reset pulses are applied only to cells clocked from product terms.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int CFG_W          = 11;
    localparam int TERMS_PER_CELL = 3;
    localparam int CLUSTER_TERMS  = 4;

    typedef enum logic [1:0] {
        XS_TERM   = 2'b00,
        XS_TERM_N = 2'b01,
        XS_ONE    = 2'b10,
        XS_ZERO   = 2'b11
    } xor_sel_e;

    typedef enum logic [1:0] {
        CK_GATED  = 2'b00,
        CK_LOCAL  = 2'b01,
        CK_TERM   = 2'b10,
        CK_GLOBAL = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        AS_TERM    = 2'b00,
        AS_CLUSTER = 2'b01,
        AS_NONE_LO = 2'b10,
        AS_NONE    = 2'b11
    } async_src_e;

    typedef enum logic [1:0] {
        OE_TERM    = 2'b00,
        OE_CLUSTER = 2'b01,
        OE_ON      = 2'b10,
        OE_OFF     = 2'b11
    } oe_src_e;

    // packed MSB first: oe [10:9], rst [8:7], set [6:5], clk [4:3], comb [2], xs [1:0]
    typedef struct packed {
        oe_src_e    oe;
        async_src_e rst;
        async_src_e set;
        clk_src_e   clk;
        logic       comb;
        xor_sel_e   xs;
    } cell_cfg_t;

    typedef struct packed {
        logic lclk;
        logic set;
        logic rst;
        logic oe;
    } cluster_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } tile_t;

endpackage

// File: rtl/mc_xor_stage.sv
module mc_xor_stage
    import mc_pkg::*;
(
    input  logic     sum_in,
    input  logic     term_c,
    input  xor_sel_e sel,
    output logic     lval
);

    logic helper;

    always_comb begin
        unique case (sel)
            XS_TERM:   helper = term_c;
            XS_TERM_N: helper = ~term_c;
            XS_ONE:    helper = 1'b1;
            default:   helper = 1'b0;
        endcase
        lval = sum_in ^ helper;
    end

endmodule

// File: rtl/mc_ctrl_sel.sv
module mc_ctrl_sel
    import mc_pkg::*;
(
    input  logic      gclk,
    input  tile_t     tl,
    input  cluster_t  cl,
    input  cell_cfg_t cfg,
    output logic      cell_clk,
    output logic      clk_en,
    output logic      set_act,
    output logic      rst_act,
    output logic      oe_val,
    output logic      glob_mode
);

    // clock source and synchronous enable
    always_comb begin
        unique case (cfg.clk)
            CK_LOCAL: begin
                cell_clk = cl.lclk;
                clk_en   = 1'b1;
            end
            CK_TERM: begin
                cell_clk = tl.c;
                clk_en   = 1'b1;
            end
            CK_GATED: begin
                cell_clk = gclk;
                clk_en   = tl.c;
            end
            default: begin
                cell_clk = gclk;
                clk_en   = 1'b1;
            end
        endcase
    end

    // asynchronous set / reset sources
    always_comb begin
        unique case (cfg.set)
            AS_TERM:    set_act = tl.a;
            AS_CLUSTER: set_act = cl.set;
            default:    set_act = 1'b0;
        endcase
        unique case (cfg.rst)
            AS_TERM:    rst_act = tl.b;
            AS_CLUSTER: rst_act = cl.rst;
            default:    rst_act = 1'b0;
        endcase
    end

    // output enable source
    always_comb begin
        unique case (cfg.oe)
            OE_TERM:    oe_val = tl.b;
            OE_CLUSTER: oe_val = cl.oe;
            OE_ON:      oe_val = 1'b1;
            default:    oe_val = 1'b0;
        endcase
    end

    assign glob_mode = (cfg.clk == CK_GLOBAL);

endmodule

// File: rtl/mc_ff.sv
module mc_ff (
    input  logic gclk,
    input  logic rst_n,
    input  logic cell_clk,
    input  logic clk_en,
    input  logic d,
    input  logic set_act,
    input  logic rst_act,
    input  logic glob_mode,
    output logic q
);

    logic clr;
    logic pre;

    assign clr = ~rst_n | rst_act;
    assign pre = set_act & ~clr;

    always_ff @(posedge cell_clk or posedge clr or posedge pre) begin
        if (clr) begin
            q <= 1'b0;
        end else if (pre) begin
            q <= 1'b1;
        end else if (clk_en) begin
            q <= d;
        end
    end

    // reset source forces the stored bit low, even against an active set
    assert_reset_wins_R8: assert property (@(posedge gclk) disable iff (!rst_n)
        rst_act |-> (q == 1'b0));

    // set source alone forces the stored bit high
    assert_set_high_R7: assert property (@(posedge gclk) disable iff (!rst_n)
        (set_act && !rst_act) |-> (q == 1'b1));

    // global-clock cells take the value present at each edge
    assert_capture_R4: assert property (@(posedge gclk) disable iff (!rst_n)
        (glob_mode && !set_act && !rst_act) |=> ((q == $past(d)) || set_act || rst_act));

endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
(
    input  logic      gclk,
    input  logic      rst_n,
    input  logic      sum_in,
    input  tile_t     tl,
    input  cluster_t  cl,
    input  cell_cfg_t cfg,
    output logic      dout,
    output logic      doe,
    output logic      q
);

    logic lval;
    logic cell_clk;
    logic clk_en;
    logic set_act;
    logic rst_act;
    logic glob_mode;

    mc_xor_stage u_xor (
        .sum_in (sum_in),
        .term_c (tl.c),
        .sel    (cfg.xs),
        .lval   (lval)
    );

    mc_ctrl_sel u_ctl (
        .gclk      (gclk),
        .tl        (tl),
        .cl        (cl),
        .cfg       (cfg),
        .cell_clk  (cell_clk),
        .clk_en    (clk_en),
        .set_act   (set_act),
        .rst_act   (rst_act),
        .oe_val    (doe),
        .glob_mode (glob_mode)
    );

    mc_ff u_ff (
        .gclk      (gclk),
        .rst_n     (rst_n),
        .cell_clk  (cell_clk),
        .clk_en    (clk_en),
        .d         (lval),
        .set_act   (set_act),
        .rst_act   (rst_act),
        .glob_mode (glob_mode),
        .q         (q)
    );

    assign dout = cfg.comb ? lval : q;

    assert_comb_path_R3: assert property (@(posedge gclk) disable iff (!rst_n)
        cfg.comb |-> (dout == lval));

    assert_reg_path_R11: assert property (@(posedge gclk) disable iff (!rst_n)
        !cfg.comb |-> (dout == q));

    assert_oe_off_R9: assert property (@(posedge gclk) disable iff (!rst_n)
        (cfg.oe == OE_OFF) |-> !doe);

endmodule

// File: rtl/mc_bank.sv
module mc_bank
    import mc_pkg::*;
#(
    parameter int CELLS  = 16,
    parameter int PTERMS = 56,
    parameter int C_BASE = 10
) (
    input  logic                   gclk,
    input  logic                   rst_n,
    input  logic [CELLS-1:0]       or_sum,
    input  logic [PTERMS-1:0]      pterm,
    input  logic [CELLS*CFG_W-1:0] cell_cfg,
    output logic [CELLS-1:0]       cell_out,
    output logic [CELLS-1:0]       cell_oe,
    output logic [CELLS-1:0]       ff_state
);

    localparam int CL_BASE = PTERMS - CLUSTER_TERMS;
    localparam int A_BASE  = C_BASE - 2;

    cluster_t cl;

    assign cl = '{lclk: pterm[CL_BASE],
                  set:  pterm[CL_BASE+1],
                  rst:  pterm[CL_BASE+2],
                  oe:   pterm[CL_BASE+3]};

    generate
        for (genvar n = 0; n < CELLS; n++) begin : g_cell
            localparam int TA = A_BASE + TERMS_PER_CELL * n;
            tile_t     tl;
            cell_cfg_t cf;

            // R1: per-cell tap position fixed by the cell number
            assign tl = '{a: pterm[TA], b: pterm[TA+1], c: pterm[TA+2]};
            assign cf = cell_cfg_t'(cell_cfg[n*CFG_W +: CFG_W]);

            mc_cell u_cell (
                .gclk   (gclk),
                .rst_n  (rst_n),
                .sum_in (or_sum[n]),
                .tl     (tl),
                .cl     (cl),
                .cfg    (cf),
                .dout   (cell_out[n]),
                .doe    (cell_oe[n]),
                .q      (ff_state[n])
            );
        end
    endgenerate

endmodule

// File: tb/sim_mc_bank.sv
module sim_mc_bank;

    localparam int CLK_P = 10;
    localparam int NC    = 16;
    localparam int NP    = 56;
    localparam int CW    = 11;

    // {cell[3:0], xs[1:0], oe[1:0], sum, a, b, c, exp_out, exp_oe}
    localparam logic [13:0] VEC [12] = '{
        {4'd0,  2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {4'd0,  2'b00, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'd3,  2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd3,  2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd7,  2'b10, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'd7,  2'b10, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {4'd12, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {4'd12, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {4'd15, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {4'd15, 2'b01, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'd9,  2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'd5,  2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic              gclk;
    logic              rst_n;
    logic [NC-1:0]     or_sum;
    logic [NP-1:0]     pterm;
    logic [NC*CW-1:0]  cell_cfg;
    logic [NC-1:0]     cell_out;
    logic [NC-1:0]     cell_oe;
    logic [NC-1:0]     ff_state;

    int total;
    int bad;
    bit done;

    mc_bank u0 (
        .gclk     (gclk),
        .rst_n    (rst_n),
        .or_sum   (or_sum),
        .pterm    (pterm),
        .cell_cfg (cell_cfg),
        .cell_out (cell_out),
        .cell_oe  (cell_oe),
        .ff_state (ff_state)
    );

    initial gclk = 1'b0;
    always #(CLK_P/2) gclk = ~gclk;

    function automatic logic [10:0] mk(input logic [1:0] xs, input logic comb,
                                       input logic [1:0] ck, input logic [1:0] st,
                                       input logic [1:0] rs, input logic [1:0] oe);
        return {oe, rs, st, ck, comb, xs};
    endfunction

    task automatic put(input int n, input logic [10:0] w);
        cell_cfg[n*CW +: CW] = w;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge gclk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [13:0] v;
        int          c;
        total    = 0;
        bad      = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        or_sum   = '0;
        pterm    = '0;
        cell_cfg = '1;
        repeat (3) @(posedge gclk);
        @(negedge gclk);
        #1;
        chk("R8 reset ff_state", ff_state, 16'h0000);
        chk("R10 reset cell_out", cell_out, 16'h0000);
        chk("R10 reset cell_oe", cell_oe, 16'h0000);
        rst_n = 1'b1;

        // R10: all-ones words pass the sum through and keep outputs disabled
        @(negedge gclk);
        or_sum = 16'hA5C3;
        pterm  = 56'hF0F0_3C3C_A5A5_FF;
        #1;
        chk("R10 passthrough out", cell_out, 16'hA5C3);
        chk("R10 passthrough oe", cell_oe, 16'h0000);

        // table: R1 tap positions, R2 helper codes, R3 combinational path, R9 enables
        for (int i = 0; i < 12; i++) begin
            @(negedge gclk);
            v        = VEC[i];
            c        = int'(v[13:10]);
            cell_cfg = '1;
            put(c, mk(v[9:8], 1'b1, 2'b11, 2'b11, 2'b11, v[7:6]));
            or_sum        = '0;
            or_sum[c]     = v[5];
            pterm         = '0;
            pterm[3*c+8]  = v[4];
            pterm[3*c+9]  = v[3];
            pterm[3*c+10] = v[2];
            #1;
            chk($sformatf("R1 R2 R3 vec%0d out", i), cell_out, 16'(v[1]) << c);
            chk($sformatf("R1 R9 vec%0d oe", i), cell_oe, 16'(v[0]) << c);
        end

        @(negedge gclk);
        cell_cfg = '1;
        or_sum   = '0;
        pterm    = '0;
        @(posedge gclk);

        // R4 / R11: global clock capture, then output switched to combinational
        @(negedge gclk);
        put(2, mk(2'b11, 1'b0, 2'b11, 2'b11, 2'b11, 2'b10));
        or_sum = 16'h0004;
        #1;
        chk("R3 registered before edge", 16'(cell_out[2]), 16'h0000);
        @(posedge gclk);
        #1;
        chk("R4 capture on gclk out", 16'(cell_out[2]), 16'h0001);
        chk("R4 capture on gclk state", 16'(ff_state[2]), 16'h0001);
        @(negedge gclk);
        or_sum = '0;
        put(2, mk(2'b11, 1'b1, 2'b11, 2'b11, 2'b11, 2'b10));
        #1;
        chk("R11 comb out", 16'(cell_out[2]), 16'h0000);
        chk("R11 state visible", 16'(ff_state[2]), 16'h0001);
        @(posedge gclk);
        #1;
        chk("R4 recapture zero", 16'(ff_state[2]), 16'h0000);

        // R5: gclk with term C (pterm[22]) as enable on cell 4
        @(negedge gclk);
        cell_cfg = '1;
        put(4, mk(2'b11, 1'b0, 2'b00, 2'b11, 2'b11, 2'b10));
        or_sum = 16'h0010;
        pterm  = '0;
        @(posedge gclk);
        #1;
        chk("R5 disabled hold", 16'(ff_state[4]), 16'h0000);
        @(negedge gclk);
        pterm[22] = 1'b1;
        @(posedge gclk);
        #1;
        chk("R5 enabled load", 16'(ff_state[4]), 16'h0001);
        @(negedge gclk);
        or_sum = '0;
        pterm  = '0;
        @(posedge gclk);
        #1;
        chk("R5 hold after disable", 16'(cell_out[4]), 16'h0001);

        // R6: cell 6 on local clock pterm[52], cell 8 on its term C pterm[34]
        @(negedge gclk);
        cell_cfg = '1;
        put(6, mk(2'b11, 1'b0, 2'b01, 2'b11, 2'b11, 2'b10));
        put(8, mk(2'b11, 1'b0, 2'b10, 2'b11, 2'b11, 2'b10));
        or_sum = 16'h0140;
        pterm  = '0;
        @(posedge gclk);
        #1;
        chk("R6 gclk ignored", 16'({ff_state[8], ff_state[6]}), 16'h0000);
        @(negedge gclk);
        #1;
        pterm[52] = 1'b1;
        #1;
        chk("R6 local clock edge", 16'({ff_state[8], ff_state[6]}), 16'h0001);
        pterm[34] = 1'b1;
        #1;
        chk("R6 term C clock edge", 16'({ff_state[8], ff_state[6]}), 16'h0003);
        pterm = '0;

        // R7 / R8: asynchronous set and reset on local-clock cells 10..13
        @(negedge gclk);
        cell_cfg = '1;
        or_sum   = '0;
        pterm    = '0;
        put(10, mk(2'b11, 1'b0, 2'b01, 2'b00, 2'b11, 2'b10));
        put(11, mk(2'b11, 1'b0, 2'b01, 2'b01, 2'b11, 2'b10));
        put(12, mk(2'b11, 1'b0, 2'b01, 2'b01, 2'b00, 2'b10));
        put(13, mk(2'b11, 1'b0, 2'b01, 2'b00, 2'b01, 2'b10));
        @(posedge gclk);
        @(negedge gclk);
        #1;
        pterm[38] = 1'b1;
        #1;
        chk("R7 term A set", 16'(ff_state[10]), 16'h0001);
        pterm[38] = 1'b0;
        #1;
        chk("R7 set held after release", 16'(ff_state[10]), 16'h0001);
        pterm[53] = 1'b1;
        #1;
        chk("R7 cluster set", 16'({ff_state[12], ff_state[11]}), 16'h0003);
        pterm[45] = 1'b1;
        #1;
        chk("R8 reset beats set", 16'({ff_state[12], ff_state[11]}), 16'h0001);
        pterm[45] = 1'b0;
        pterm[53] = 1'b0;
        #1;
        pterm[47] = 1'b1;
        #1;
        chk("R7 term A set cell13", 16'(ff_state[13]), 16'h0001);
        pterm[54] = 1'b1;
        #1;
        chk("R8 cluster reset", 16'(ff_state[13]), 16'h0000);
        pterm[47] = 1'b0;
        #1;
        pterm[54] = 1'b0;

        // R9: cluster output enable pterm[55] on cell 1
        @(negedge gclk);
        cell_cfg = '1;
        pterm    = '0;
        put(1, mk(2'b11, 1'b1, 2'b11, 2'b11, 2'b11, 2'b01));
        pterm[55] = 1'b1;
        #1;
        chk("R9 cluster oe high", cell_oe, 16'h0002);
        pterm[55] = 1'b0;
        #1;
        chk("R9 cluster oe low", cell_oe, 16'h0000);

        // R8: rst_n clears every flip-flop
        @(negedge gclk);
        cell_cfg = '1;
        or_sum   = 16'hFFFF;
        @(posedge gclk);
        @(negedge gclk);
        #1;
        chk("R4 all cells loaded", ff_state, 16'hFFFF);
        rst_n = 1'b0;
        #1;
        chk("R8 rst_n clears", ff_state, 16'h0000);
        @(negedge gclk);
        or_sum = '0;
        rst_n  = 1'b1;
        @(negedge gclk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule